// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block sits beside the core of an 8-bit processor and decides which of five hardware interrupt requests the core should take next. The five inputs have a fixed priority. The highest one is a non-maskable request that is captured on its rising edge. Below it are three vectored maskable requests: one edge-captured and two level-sensitive. The lowest is a general maskable request that carries no vector, and the core serves it through a separate acknowledge. A global enable gates every maskable source. Each of the three vectored maskable sources also has its own mask bit.

The core drives a mask-write strobe with a data byte to load the three individual masks and to discard a captured edge request. It reads back a status byte that shows the masks, the global enable and the pending state of the three vectored maskable sources. The block drives a request line and a 16-bit vector address that are ready in the same cycle. When the core accepts a request, it pulses an acceptance input in that cycle. Separately, the block turns a 3-bit software restart number n into the address n×8.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request output is low, the global enable is off, and all three individual masks are set, so the status byte reads 0x07.
- R2: A rising edge on `irq_nmi` is captured and requests vector 0x0024 from the next cycle on, whatever the enable and mask state. The capture stays pending after the input falls and is cleared only by acceptance, which leaves the global enable unchanged.
- R3: When several sources are eligible, the one granted follows this fixed order from highest to lowest: `irq_nmi`, `irq_edge`, `irq_lvl_hi`, `irq_lvl_lo`, `irq_gen`.
- R4: A rising edge on `irq_edge` sets a capture that is pending from the next cycle and stays set while masked. It is shown in status bit 6 and cleared either by acceptance of that source or by a mask write with data bit 4 set.
- R5: `irq_lvl_hi` and `irq_lvl_lo` are not captured. They request only while high, and status bits 5 and 4 follow them directly.
- R6: `ie_set` turns the global enable on and `ie_clr` turns it off; `ie_set` wins if both are high. While the enable is off, no maskable source raises the request. The enable is shown in status bit 3.
- R7: A mask write with data bit 3 set loads data bits 2, 1 and 0 as the masks of `irq_edge`, `irq_lvl_hi` and `irq_lvl_lo`, where 1 means blocked. With bit 3 clear, the masks keep their value. Status bits 2..0 show the masks.
- R8: Acceptance of any maskable source (request high and `int_ack` high in the same cycle) clears the global enable from the next cycle, even if `ie_set` is high in that cycle.
- R9: The general source presents vector 0x0000. `gen_ack` is high exactly in a cycle where that source is granted and accepted.
- R10: The vectors are 0x003C for `irq_edge`, 0x0034 for `irq_lvl_hi` and 0x002C for `irq_lvl_lo`.
- R11: `swi_vec` equals `swi_num` times 8, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_nmi | input | 1 | Non-maskable request, rising-edge captured |
| irq_edge | input | 1 | Maskable vectored request, rising-edge captured |
| irq_lvl_hi | input | 1 | Maskable vectored request, level |
| irq_lvl_lo | input | 1 | Maskable vectored request, level |
| irq_gen | input | 1 | Maskable non-vectored request, level |
| ie_set | input | 1 | Global enable on |
| ie_clr | input | 1 | Global enable off |
| mask_wr | input | 1 | Mask-write strobe |
| mask_wdata | input | 5 | Mask-write data (bit 4 discard edge capture, bit 3 load, bits 2..0 masks) |
| mask_rdata | output | 8 | Status byte |
| int_ack | input | 1 | Core accepts the current request |
| int_req | output | 1 | Request to the core |
| int_vec | output | 16 | Vector of the granted source |
| gen_ack | output | 1 | Acknowledge for the general source |
| swi_num | input | 3 | Software restart number |
| swi_vec | output | 16 | Software restart address |

## Verification
The hardest case to reach from the ports is an edge capture that was taken while its source was masked and is later unmasked while a level source of lower priority is also active. The stimulus raises and drops `irq_edge` under a full mask with `irq_lvl_hi` held high, then enables and unmasks in one cycle. It checks that the edge vector wins, and that acceptance clears both the capture and the enable. A long seeded random phase then mixes enable changes, mask writes with arbitrary bytes and acceptances that land on every source. A bench-side model predicts every output in every cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_SRC     = 5;
    localparam int NUM_EDGE    = 2;
    localparam int NUM_MASK    = 3;
    localparam int WR_W        = 5;

    // source index doubles as priority rank (0 = highest)
    localparam int S_NMI    = 0;
    localparam int S_EDGE   = 1;
    localparam int S_LVL_HI = 2;
    localparam int S_LVL_LO = 3;
    localparam int S_GEN    = 4;

    // mask-write byte fields
    localparam int WB_LOAD_EN  = 3;
    localparam int WB_EDGE_CLR = 4;

    // mask bit positions
    localparam int MB_LVL_LO = 0;
    localparam int MB_LVL_HI = 1;
    localparam int MB_EDGE   = 2;

    typedef struct packed {
        logic [NUM_MASK-1:0] mask;
        logic                ie;
    } ctl_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } cap_t;

endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic clr,
    output logic pend
);

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = req_in;
        // a fresh edge in the clearing cycle is kept
        cap_d.pend = (cap_q.pend & ~clr) | (req_in & ~cap_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pend = cap_q.pend;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant,
    output logic         any
);

    // lowest index has the highest rank
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign any = |elig;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int               VEC_W      = 16,
    parameter int               SWI_W      = 3,
    parameter int               SWI_SHIFT  = 3,
    parameter logic [VEC_W-1:0] VEC_NMI    = 16'h0024,
    parameter logic [VEC_W-1:0] VEC_EDGE   = 16'h003C,
    parameter logic [VEC_W-1:0] VEC_LVL_HI = 16'h0034,
    parameter logic [VEC_W-1:0] VEC_LVL_LO = 16'h002C,
    parameter logic [VEC_W-1:0] VEC_GEN    = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_nmi,
    input  logic             irq_edge,
    input  logic             irq_lvl_hi,
    input  logic             irq_lvl_lo,
    input  logic             irq_gen,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             mask_wr,
    input  logic [WR_W-1:0]  mask_wdata,
    output logic [7:0]       mask_rdata,
    input  logic             int_ack,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec,
    output logic             gen_ack,
    input  logic [SWI_W-1:0] swi_num,
    output logic [VEC_W-1:0] swi_vec
);

    localparam int SWI_PAD = VEC_W - SWI_W - SWI_SHIFT;
    localparam logic [VEC_W-1:0] VEC_TAB [NUM_SRC] =
        '{VEC_NMI, VEC_EDGE, VEC_LVL_HI, VEC_LVL_LO, VEC_GEN};

    ctl_t ctl_d, ctl_q;

    logic [NUM_EDGE-1:0] edge_raw;
    logic [NUM_EDGE-1:0] edge_clr;
    logic [NUM_EDGE-1:0] edge_pend;
    logic [NUM_SRC-1:0]  elig;
    logic [NUM_SRC-1:0]  grant;
    logic                any_req;
    logic                accept;
    logic                ie_now;
    logic [NUM_MASK-1:0] mask_now;

    assign edge_raw = {irq_edge, irq_nmi};

    // one capture stage per edge-sensitive source
    for (genvar g = 0; g < NUM_EDGE; g++) begin : g_cap
        irq_edge_cap u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_in (edge_raw[g]),
            .clr    (edge_clr[g]),
            .pend   (edge_pend[g])
        );
    end

    always_comb begin
        elig[S_NMI]    = edge_pend[0];
        elig[S_EDGE]   = ctl_q.ie & edge_pend[1] & ~ctl_q.mask[MB_EDGE];
        elig[S_LVL_HI] = ctl_q.ie & irq_lvl_hi   & ~ctl_q.mask[MB_LVL_HI];
        elig[S_LVL_LO] = ctl_q.ie & irq_lvl_lo   & ~ctl_q.mask[MB_LVL_LO];
        elig[S_GEN]    = ctl_q.ie & irq_gen;
    end

    irq_arbiter #(.N(NUM_SRC)) u_arb (
        .elig  (elig),
        .grant (grant),
        .any   (any_req)
    );

    assign accept = any_req & int_ack;

    // next-state computation
    always_comb begin
        ctl_d = ctl_q;
        if (mask_wr && mask_wdata[WB_LOAD_EN]) begin
            ctl_d.mask = mask_wdata[NUM_MASK-1:0];
        end
        if (ie_set) begin
            ctl_d.ie = 1'b1;
        end else if (ie_clr) begin
            ctl_d.ie = 1'b0;
        end
        if (accept && !grant[S_NMI]) begin
            ctl_d.ie = 1'b0;
        end
        edge_clr[0] = accept & grant[S_NMI];
        edge_clr[1] = (accept & grant[S_EDGE]) | (mask_wr & mask_wdata[WB_EDGE_CLR]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mask <= '1;
            ctl_q.ie   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        int_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                int_vec = int_vec | VEC_TAB[i];
            end
        end
    end

    assign int_req    = any_req;
    assign gen_ack    = accept & grant[S_GEN];
    assign mask_rdata = {1'b0, edge_pend[1], irq_lvl_hi, irq_lvl_lo, ctl_q.ie, ctl_q.mask};
    assign swi_vec    = {{SWI_PAD{1'b0}}, swi_num, {SWI_SHIFT{1'b0}}};
    assign ie_now     = ctl_q.ie;
    assign mask_now   = ctl_q.mask;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int               VEC_W      = 16,
    parameter logic [VEC_W-1:0] VEC_NMI    = 16'h0024,
    parameter logic [VEC_W-1:0] VEC_LVL_LO = 16'h002C,
    parameter logic [VEC_W-1:0] VEC_GEN    = 16'h0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_nmi,
    input logic             int_req,
    input logic             int_ack,
    input logic [VEC_W-1:0] int_vec,
    input logic             gen_ack,
    input logic [VEC_W-1:0] swi_vec,
    input logic             ie_now,
    input logic [2:0]       mask_now,
    input logic             nmi_pend
);

    p_nmi_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_nmi) |=> (int_req && int_vec == VEC_NMI));

    p_ie_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_now && !nmi_pend) |-> !int_req);

    p_lo_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_now[0] && int_req) |-> (int_vec != VEC_LVL_LO));

    p_accept_drops_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && int_vec != VEC_NMI) |=> !ie_now);

    p_gen_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gen_ack |-> (int_req && int_ack && int_vec == VEC_GEN));

    p_swi_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_vec[2:0] == 3'b000) && (swi_vec < 16'h0040));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .VEC_W      (VEC_W),
    .VEC_NMI    (VEC_NMI),
    .VEC_LVL_LO (VEC_LVL_LO),
    .VEC_GEN    (VEC_GEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_nmi  (irq_nmi),
    .int_req  (int_req),
    .int_ack  (int_ack),
    .int_vec  (int_vec),
    .gen_ack  (gen_ack),
    .swi_vec  (swi_vec),
    .ie_now   (ie_now),
    .mask_now (mask_now),
    .nmi_pend (edge_pend[0])
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_nmi = 0, irq_edge = 0, irq_lvl_hi = 0, irq_lvl_lo = 0, irq_gen = 0;
    logic        ie_set = 0, ie_clr = 0, mask_wr = 0, int_ack = 0;
    logic [4:0]  mask_wdata = '0;
    logic [2:0]  swi_num = '0;
    logic [7:0]  mask_rdata;
    logic        int_req, gen_ack;
    logic [15:0] int_vec, swi_vec;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    bit       m_nmi_p, m_nmi_prev, m_edge_p, m_edge_prev, m_ie;
    bit [2:0] m_mask;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .irq_nmi(irq_nmi), .irq_edge(irq_edge), .irq_lvl_hi(irq_lvl_hi),
        .irq_lvl_lo(irq_lvl_lo), .irq_gen(irq_gen),
        .ie_set(ie_set), .ie_clr(ie_clr),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec), .gen_ack(gen_ack),
        .swi_num(swi_num), .swi_vec(swi_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // 0 none, 1 nmi, 2 edge, 3 lvl_hi, 4 lvl_lo, 5 gen
    function automatic int m_sel();
        if (m_nmi_p) return 1;
        if (!m_ie) return 0;
        if (m_edge_p && !m_mask[2]) return 2;
        if (irq_lvl_hi && !m_mask[1]) return 3;
        if (irq_lvl_lo && !m_mask[0]) return 4;
        if (irq_gen) return 5;
        return 0;
    endfunction

    function automatic logic [15:0] m_vec(input int s);
        case (s)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [7:0] m_rdata();
        return {1'b0, m_edge_p, irq_lvl_hi, irq_lvl_lo, m_ie, m_mask};
    endfunction

    task automatic compare_all();
        int s;
        s = m_sel();
        chk("R3 request", int_req, s != 0);
        if (s != 0) chk("R10 vector", int_vec, m_vec(s));
        chk("R9 gen_ack", gen_ack, (s == 5) && int_ack);
        chk("R7 status", mask_rdata, m_rdata());
        chk("R11 swi", swi_vec, {10'b0, swi_num, 3'b000});
    endtask

    task automatic model_next();
        int  s;
        bit  acc;
        s   = m_sel();
        acc = (s != 0) && int_ack;
        m_nmi_p  = (m_nmi_p & ~(acc && s == 1)) | (irq_nmi & ~m_nmi_prev);
        m_edge_p = (m_edge_p & ~(acc && s == 2) & ~(mask_wr & mask_wdata[4])) | (irq_edge & ~m_edge_prev);
        if (mask_wr && mask_wdata[3]) m_mask = mask_wdata[2:0];
        if (ie_set) m_ie = 1;
        else if (ie_clr) m_ie = 0;
        if (acc && s != 1) m_ie = 0;
        m_nmi_prev  = irq_nmi;
        m_edge_prev = irq_edge;
    endtask

    task automatic step();
        #2;
        compare_all();
        model_next();
        @(posedge clk);
        #1;
        ie_set = 0; ie_clr = 0; mask_wr = 0; int_ack = 0;
    endtask

    task automatic peek();
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd9041));
        m_nmi_p = 0; m_nmi_prev = 0; m_edge_p = 0; m_edge_prev = 0; m_ie = 0; m_mask = 3'b111;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        peek();
        chk("R1 req after reset", int_req, 0);
        chk("R1 status after reset", mask_rdata, 8'h07);

        for (int n = 0; n < 8; n++) begin
            swi_num = n[2:0];
            #0.5;
            chk("R11 swi", swi_vec, n * 8);
        end

        irq_gen = 1; step(); peek();
        chk("R6 gen blocked while disabled", int_req, 0);
        ie_set = 1; step(); peek();
        chk("R6 enable bit", mask_rdata[3], 1);
        chk("R9 gen request", int_req, 1);
        chk("R9 gen vector", int_vec, 16'h0000);
        int_ack = 1; peek();
        chk("R9 gen_ack on accept", gen_ack, 1);
        step(); peek();
        chk("R8 enable dropped", mask_rdata[3], 0);
        chk("R9 gen_ack idle", gen_ack, 0);
        irq_gen = 0;

        ie_set = 1; mask_wr = 1; mask_wdata = 5'h08; step(); peek();
        chk("R7 masks cleared", mask_rdata[2:0], 3'b000);
        irq_lvl_lo = 1; peek();
        chk("R10 lvl_lo vector", int_vec, 16'h002C);
        chk("R5 lvl_lo status", mask_rdata[4], 1);
        irq_lvl_hi = 1; peek();
        chk("R3 lvl_hi over lvl_lo", int_vec, 16'h0034);
        mask_wr = 1; mask_wdata = 5'h0A; step(); peek();
        chk("R7 lvl_hi masked", int_vec, 16'h002C);
        mask_wr = 1; mask_wdata = 5'h02; step(); peek();
        chk("R7 no load without bit3", mask_rdata[2:0], 3'b010);

        irq_edge = 1; step(); irq_edge = 0; step(); peek();
        chk("R4 edge vector", int_vec, 16'h003C);
        chk("R4 edge pending bit", mask_rdata[6], 1);
        mask_wr = 1; mask_wdata = 5'h1C; step(); peek();
        chk("R4 edge discarded", mask_rdata[6], 0);
        chk("R3 lvl_hi after discard", int_vec, 16'h0034);
        ie_clr = 1; step(); peek();
        chk("R6 disabled blocks levels", int_req, 0);

        irq_nmi = 1; step(); peek();
        chk("R2 nmi vector", int_vec, 16'h0024);
        irq_nmi = 0; step(); peek();
        chk("R2 nmi held", int_req, 1);
        int_ack = 1; step(); peek();
        chk("R2 nmi cleared", int_req, 0);
        chk("R2 enable untouched", mask_rdata[3], 0);

        mask_wr = 1; mask_wdata = 5'h0F; irq_edge = 1; step(); irq_edge = 0; peek();
        chk("R4 captured while masked", mask_rdata[6], 1);
        ie_set = 1; mask_wr = 1; mask_wdata = 5'h08; step(); peek();
        chk("R3 edge over lvl_hi", int_vec, 16'h003C);
        int_ack = 1; step(); peek();
        chk("R4 accept clears edge", mask_rdata[6], 0);
        chk("R8 accept drops enable", mask_rdata[3], 0);
        irq_lvl_hi = 0; irq_lvl_lo = 0; step();

        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 24 == 0) irq_nmi = ~irq_nmi;
            if ($urandom % 6 == 0) irq_edge = ~irq_edge;
            irq_lvl_hi = ($urandom % 3 == 0);
            irq_lvl_lo = ($urandom % 3 == 0);
            irq_gen    = ($urandom % 4 == 0);
            ie_set     = ($urandom % 5 == 0);
            ie_clr     = ($urandom % 9 == 0);
            mask_wr    = ($urandom % 10 == 0);
            mask_wdata = 5'($urandom);
            int_ack    = ($urandom % 2 == 0);
            swi_num    = 3'($urandom);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule